// File: doc/BRIEF.md
# Multi-Width SPI Byte Shift Engine

This block is the shifting core of a SPI master. Each request moves one byte across the serial pins over one, two or four data lanes. The host supplies the byte, a lane-width code and a direction flag. When the transfer completes, the block returns the captured byte together with a one-cycle completion strobe. On the pin side it generates the serial clock in mode 0, so the clock idles low and data changes while the clock is low. It also provides one output-enable per data lane, so a lane can be driven or released for the device to drive.

Chip-select, command framing and any knowledge of memory devices belong to the logic around this block. A single shift register handles every width. In single-lane mode it runs full duplex: it drives lane 0 and samples lane 1. In dual-lane and quad-lane modes, every lane in use either drives or listens. The parameter `CLK_DIV` (at least 1) gives the number of system clocks in each half-period of the serial clock.

Top module: `spi_lane_shifter`

## Requirements
- R1: While reset is asserted and after it is released, `sclk`, `io_oe`, `io_out`, `busy` and `done` are all 0.
- R2: Width code 0 (single lane) transmit puts the byte on `io_out[0]` most significant bit first, using 8 serial clock pulses. During the same transfer, `io_in[1]` is sampled once per pulse while `sclk` is high, MSB first, and the result is returned on `rx_byte`. `io_oe` is 4'b0001.
- R3: Single-lane receive (`req_rx`=1, width code 0 or 3) drives 1 on `io_out[0]` for all 8 pulses, so 0xFF goes out while `io_in[1]` is captured. `io_oe` is 4'b0001.
- R4: Width code 1 (dual lane) sends two bits per pulse over 4 pulses, the first pair being bits 7:6. The higher bit of each pair is on lane 1 and the lower bit on lane 0. For transmit, `io_oe` is 4'b0011.
- R5: Width code 2 (quad lane) sends one nibble per pulse over 2 pulses, upper nibble first. Bit 3 of the nibble is on lane 3 and bit 0 on lane 0. For transmit, `io_oe` is 4'b1111.
- R6: In dual-lane or quad-lane receive, `io_oe` is 4'b0000 for the whole transfer. The lanes in use are sampled with the same bit-to-lane mapping as R4 and R5, and the assembled byte is returned on `rx_byte`.
- R7: `sclk` is low whenever the block is idle. Every high and low phase of `sclk` within a transfer lasts exactly `CLK_DIV` clocks. The first rising edge comes `CLK_DIV` clocks after the lane enables are applied.
- R8: A request arriving while `busy` is 1 is ignored. It does not change the running transfer and it does not start another one afterwards.
- R9: `done` is high for exactly one cycle, in the cycle after the final falling edge of `sclk`. That cycle is 2·N·`CLK_DIV`+1 clocks after the edge that accepts the request, where N is the number of pulses. `rx_byte` is valid at `done` and holds its value until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start request, taken only while idle |
| req_byte | input | 8 | Byte to transmit |
| req_width | input | 2 | Lane width: 0 single, 1 dual, 2 quad, 3 single |
| req_rx | input | 1 | 1 = receive, 0 = transmit |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion strobe |
| rx_byte | output | 8 | Byte captured from the data lanes |
| sclk | output | 1 | Serial clock, mode 0 |
| io_out | output | 4 | Data driven on lanes 0..3 |
| io_oe | output | 4 | Per-lane output enable |
| io_in | input | 4 | Data sampled from lanes 0..3 |

## Verification
The hardest case to reach from the ports is a request that arrives in the middle of a transfer, because the block has to ignore it both at that moment and afterwards. The stimulus pulses `req_valid` with a different width and direction partway through one transfer. It then checks that the pulse count, the lane data and the enables match the original request, and that `busy` stays low after `done`. A device model on `io_in` advances on every falling edge of `sclk`, so sampling on the wrong phase of the clock produces a byte that does not match.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 4;

  typedef enum logic [1:0] {LW_X1 = 2'd0, LW_X2 = 2'd1, LW_X4 = 2'd2} lane_w_e;

  typedef enum logic [2:0] {PH_IDLE, PH_LEAD, PH_HIGH, PH_LOW, PH_TAIL} phase_e;

  // code 3 is folded onto single lane
  function automatic logic [1:0] norm_width(input logic [1:0] w);
    return (w == 2'd3) ? LW_X1 : w;
  endfunction

  function automatic int unsigned lanes_of(input logic [1:0] w);
    case (norm_width(w))
      LW_X2:   return 2;
      LW_X4:   return 4;
      default: return 1;
    endcase
  endfunction

  function automatic int unsigned pulses_of(input logic [1:0] w);
    return BYTE_W / lanes_of(w);
  endfunction

  function automatic logic [LANES-1:0] oe_of(input logic [1:0] w, input logic rx);
    case (norm_width(w))
      LW_X2:   return rx ? 4'b0000 : 4'b0011;
      LW_X4:   return rx ? 4'b0000 : 4'b1111;
      default: return 4'b0001;
    endcase
  endfunction
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int CLK_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = $clog2(CLK_DIV + 1);
  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == CNT_W'(CLK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_lane_shift.sv
module spi_lane_shift
  import spi_shift_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [BW-1:0] load_val,
  input  logic [1:0]    width,
  input  logic          shift,
  input  logic          sample,
  input  logic [3:0]    io_in,
  output logic [3:0]    lane_out,
  output logic [BW-1:0] rx_byte
);
  logic [BW-1:0] tx_sh;
  logic [BW-1:0] rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
      rx_sh <= '0;
    end else if (load) begin
      tx_sh <= load_val;
      rx_sh <= '0;
    end else begin
      if (shift) begin
        case (width)
          LW_X2:   tx_sh <= {tx_sh[BW-3:0], 2'b00};
          LW_X4:   tx_sh <= {tx_sh[BW-5:0], 4'b0000};
          default: tx_sh <= {tx_sh[BW-2:0], 1'b0};
        endcase
      end
      if (sample) begin
        case (width)
          LW_X2:   rx_sh <= {rx_sh[BW-3:0], io_in[1:0]};
          LW_X4:   rx_sh <= {rx_sh[BW-5:0], io_in};
          default: rx_sh <= {rx_sh[BW-2:0], io_in[1]};
        endcase
      end
    end
  end

  // fixed bit-to-lane mapping: the top bits of the shifter sit on the highest lane in use
  for (genvar g = 0; g < 4; g++) begin : g_lane
    if (g < 2) begin : g_low
      assign lane_out[g] = (width == LW_X4) ? tx_sh[BW-4+g] :
                           (width == LW_X2) ? tx_sh[BW-2+g] :
                           (g == 0)         ? tx_sh[BW-1]   : 1'b0;
    end else begin : g_high
      assign lane_out[g] = (width == LW_X4) ? tx_sh[BW-4+g] : 1'b0;
    end
  end

  assign rx_byte = rx_sh;
endmodule

// File: rtl/spi_lane_shifter.sv
module spi_lane_shifter
  import spi_shift_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [7:0]  req_byte,
  input  logic [1:0]  req_width,
  input  logic        req_rx,
  output logic        busy,
  output logic        done,
  output logic [7:0]  rx_byte,
  output logic        sclk,
  output logic [3:0]  io_out,
  output logic [3:0]  io_oe,
  input  logic [3:0]  io_in
);
  localparam int BEAT_W = $clog2(BYTE_W);

  phase_e            phase;
  logic [1:0]        cur_width;
  logic              cur_rx;
  logic [BEAT_W-1:0] beats_left;
  logic              sclk_q, done_q;
  logic [3:0]        oe_q;
  logic [3:0]        lane_out;

  // named events
  logic accept, tick, timed, rise_ev, fall_ev, last_beat;

  assign accept    = req_valid && (phase == PH_IDLE);
  assign timed     = (phase == PH_LEAD) || (phase == PH_HIGH) || (phase == PH_LOW);
  assign rise_ev   = tick && (phase == PH_LEAD || phase == PH_LOW);
  assign fall_ev   = tick && (phase == PH_HIGH);
  assign last_beat = (beats_left == '0);

  spi_half_timer #(.CLK_DIV(CLK_DIV)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(timed), .tick(tick)
  );

  spi_lane_shift #(.BW(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(accept),
    .load_val(req_rx ? 8'hFF : req_byte),
    .width(cur_width),
    .shift(fall_ev && !last_beat),
    .sample(fall_ev),
    .io_in(io_in),
    .lane_out(lane_out),
    .rx_byte(rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      cur_width  <= LW_X1;
      cur_rx     <= 1'b0;
      beats_left <= '0;
      sclk_q     <= 1'b0;
      done_q     <= 1'b0;
      oe_q       <= '0;
    end else begin
      done_q <= 1'b0;
      case (phase)
        PH_IDLE: if (accept) begin
          phase      <= PH_LEAD;
          cur_width  <= norm_width(req_width);
          cur_rx     <= req_rx;
          oe_q       <= oe_of(req_width, req_rx);
          beats_left <= BEAT_W'(pulses_of(req_width) - 1);
        end
        PH_LEAD, PH_LOW: if (rise_ev) begin
          phase  <= PH_HIGH;
          sclk_q <= 1'b1;
        end
        PH_HIGH: if (fall_ev) begin
          sclk_q <= 1'b0;
          if (last_beat) phase <= PH_TAIL;
          else begin
            phase      <= PH_LOW;
            beats_left <= beats_left - 1'b1;
          end
        end
        PH_TAIL: begin
          phase  <= PH_IDLE;
          done_q <= 1'b1;
          oe_q   <= '0;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy   = (phase != PH_IDLE);
  assign done   = done_q;
  assign sclk   = sclk_q;
  assign io_oe  = oe_q;
  assign io_out = lane_out & oe_q;
endmodule

// File: rtl/spi_lane_shifter_chk.sv
module spi_lane_shifter_chk
  import spi_shift_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sclk,
  input logic       busy,
  input logic       done,
  input logic [3:0] io_oe,
  input logic [1:0] cur_width,
  input logic       cur_rx
);
  localparam int HW = $clog2(CLK_DIV + 2) + 1;
  logic          sclk_d;
  logic [3:0]    rise_cnt;
  logic [HW-1:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      rise_cnt <= '0;
      hi_len   <= '0;
    end else begin
      sclk_d <= sclk;
      if (!busy)                rise_cnt <= '0;
      else if (sclk && !sclk_d) rise_cnt <= rise_cnt + 1'b1;
      hi_len <= sclk ? hi_len + 1'b1 : '0;
    end
  end

  p_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  p_high_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_d && !sclk) |-> (hi_len == HW'(CLK_DIV)));

  p_oe_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(io_oe)));

  p_rx_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cur_rx && cur_width != LW_X1) |-> (io_oe == 4'b0000));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!$past(sclk) && $past(sclk, 2)));

  p_pulse_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rise_cnt == 4'(pulses_of(cur_width))));
endmodule

bind spi_lane_shifter spi_lane_shifter_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .busy(busy), .done(done),
  .io_oe(io_oe), .cur_width(cur_width), .cur_rx(cur_rx)
);

// File: tb/tb_spi_lane_shifter.sv
module tb_spi_lane_shifter;
  localparam int CLK_PERIOD = 10;
  localparam int K = 3;

  typedef struct {
    logic [1:0] w;
    logic       rx;
    logic [7:0] tx;
    logic [7:0] slave;
    logic [3:0] oe;
    int         n;
    int         stamp;
    string      tag;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_rx = 0;
  logic [7:0] req_byte = 0;
  logic [1:0] req_width = 0;
  logic busy, done, sclk;
  logic [7:0] rx_byte;
  logic [3:0] io_out, io_oe, io_in;

  spi_lane_shifter #(.CLK_DIV(K)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_byte(req_byte),
    .req_width(req_width), .req_rx(req_rx), .busy(busy), .done(done),
    .rx_byte(rx_byte), .sclk(sclk), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  item_t sb[$];

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic int lanes(input logic [1:0] w);
    return (w == 2'd1) ? 2 : (w == 2'd2) ? 4 : 1;
  endfunction

  // device model: presents one chunk, advanced on every sclk fall
  logic [7:0] slave_byte = 0;
  logic [1:0] slave_w = 0;
  int slave_idx = 0;
  always_comb begin
    logic [7:0] t;
    t = slave_byte << (lanes(slave_w) * slave_idx);
    io_in = 4'b0000;
    if (slave_w == 2'd1)      io_in[1:0] = t[7:6];
    else if (slave_w == 2'd2) io_in      = t[7:4];
    else                      io_in[1]   = t[7];
  end

  always @(posedge clk) cyc <= cyc + 1;

  // monitor
  logic sclk_prev = 0;
  int rises = 0, hi_run = 0, lo_run = 0;
  logic [7:0] tx_seen = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && sclk && !sclk_prev && sb.size() > 0) begin
        int l;
        l = lanes(sb[0].w);
        rises++;
        chk(lo_run == K, "R7 low phase length", lo_run, K);
        chk(io_oe == sb[0].oe, {sb[0].tag, " lane enables"}, io_oe, sb[0].oe);
        if (l == 1)      tx_seen = {tx_seen[6:0], io_out[0]};
        else if (l == 2) tx_seen = {tx_seen[5:0], io_out[1:0]};
        else             tx_seen = {tx_seen[3:0], io_out};
        lo_run = 0;
      end
      if (!sclk && sclk_prev) begin
        chk(hi_run == K, "R7 high phase length", hi_run, K);
        slave_idx++;
        hi_run = 0;
      end
      if (sclk) hi_run++;
      else if (busy) lo_run++;
      if (!busy && !done) chk(sclk == 1'b0, "R7 idle sclk", sclk, 0);
      if (done) begin
        if (sb.size() == 0) chk(0, "R8 unexpected done", 1, 0);
        else begin
          item_t e;
          e = sb.pop_front();
          chk(rises == e.n, {e.tag, " pulse count"}, rises, e.n);
          if (!(e.rx && e.w != 2'd0))
            chk(tx_seen == e.tx, {e.tag, " lane data out"}, tx_seen, e.tx);
          if (e.rx || e.w == 2'd0)
            chk(rx_byte == e.slave, {e.tag, " captured byte"}, rx_byte, e.slave);
          chk(cyc - e.stamp == 2*e.n*K + 2, "R9 done latency", cyc - e.stamp, 2*e.n*K + 2);
        end
        rises = 0; tx_seen = 0; lo_run = 0;
      end
      sclk_prev = sclk;
    end
  end

  task automatic xfer(input logic [1:0] w, input logic rx, input logic [7:0] tx,
                      input logic [7:0] slave, input logic [3:0] oe,
                      input string tag, input bit poke);
    item_t e;
    logic [7:0] hold;
    @(negedge clk);
    slave_byte = slave; slave_w = w; slave_idx = 0;
    e.w = w; e.rx = rx; e.slave = slave; e.oe = oe; e.tag = tag;
    e.tx = rx ? 8'hFF : tx;
    e.n = 8 / lanes(w); e.stamp = cyc;
    sb.push_back(e);
    req_width = w; req_rx = rx; req_byte = tx; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    if (poke) begin
      repeat (4) @(negedge clk);
      req_width = 2'd2; req_rx = ~rx; req_byte = ~tx; req_valid = 1;  // R8 stray request
      @(negedge clk);
      req_valid = 0;
    end
    while (!done) @(negedge clk);
    hold = rx_byte;
    @(negedge clk);
    chk(done == 1'b0, "R9 done width", done, 0);
    chk(io_oe == 4'b0000, "R1 enables released after done", io_oe, 0);
    repeat (3) @(negedge clk);
    chk(rx_byte == hold, "R9 rx_byte held", rx_byte, hold);
    if (poke) chk(busy == 1'b0, "R8 no second transfer", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sclk == 0 && io_oe == 0 && busy == 0 && done == 0 && io_out == 0,
        "R1 state in reset", {sclk, io_oe, busy, done}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(sclk == 0 && io_oe == 0 && busy == 0 && done == 0,
        "R1 state after reset", {sclk, io_oe, busy, done}, 0);
    xfer(2'd0, 0, 8'hA5, 8'h3C, 4'b0001, "R2 x1 duplex", 0);
    xfer(2'd0, 1, 8'h00, 8'hC6, 4'b0001, "R3 x1 receive", 0);
    xfer(2'd3, 1, 8'h12, 8'h81, 4'b0001, "R3 code3 receive", 0);
    xfer(2'd1, 0, 8'h9B, 8'h00, 4'b0011, "R4 x2 transmit", 0);
    xfer(2'd1, 1, 8'h00, 8'h5E, 4'b0000, "R6 x2 receive", 0);
    xfer(2'd2, 0, 8'hD2, 8'h00, 4'b1111, "R5 x4 transmit", 0);
    xfer(2'd2, 1, 8'h00, 8'h7A, 4'b0000, "R6 x4 receive", 0);
    xfer(2'd0, 0, 8'h6E, 8'hB1, 4'b0001, "R8 x1 with stray request", 1);
    xfer(2'd1, 0, 8'h27, 8'h00, 4'b0011, "R8 x2 with stray request", 1);
    xfer(2'd2, 0, 8'hFF, 8'h00, 4'b1111, "R5 x4 all ones", 0);
    xfer(2'd1, 0, 8'h00, 8'h00, 4'b0011, "R4 x2 all zeros", 0);
    chk(sb.size() == 0, "R9 all transfers completed", sb.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R9 actual=%0h expected=%0h", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule